// File: doc/BRIEF.md
# Reset-Gated Register OR Multiplexer

This block selects one word out of a wide set of equal-width sources without any tristate bus. Each source feeds a register of its own, and every such register has a synchronous clear. A binary select index is decoded into a one-hot "open" vector. Only the register of the selected source is allowed to load its data. All the others are held cleared. Because the cleared registers contribute all-zero words, the output is a plain OR of every register output, built as a balanced tree.

The gating is done by the registers, so the selection is synchronous. The output word shows the source data and select index that were present at the previous rising clock edge. A select index beyond the last source opens no register, and the output then reads zero. The number of sources and the word width are parameters, with defaults of 16 sources of 32 bits.

Top module: `rgom_mux`

## Requirements
- R1: While `rst` is high at a rising edge, every source register clears, so the output is zero in the following cycle. The output also reads zero in the first cycle after `rst` is released.
- R2: When the select index is in range (below the source count), the output after a rising edge equals the word of that source sampled at that edge. Source k is taken from `src_data[k*DATA_W +: DATA_W]`.
- R3: The output never combines two sources. With distinct data on every source, the output equals the selected word exactly.
- R4: Data on unselected sources has no effect on the output. Changing those sources while the select is held leaves the output at the selected word.
- R5: A select index equal to or greater than the source count opens no register, so the output is zero one cycle later.
- R6: The selection is synchronous. A change of `sel_idx` or `src_data` between edges leaves the output unchanged until the next rising edge.
- R7: The first source (index 0) and the last source (index N-1) are both selectable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears every source register |
| src_data | input | NUM_SRC*DATA_W | Packed source words, source k at bits [k*DATA_W +: DATA_W] |
| sel_idx | input | $clog2(NUM_SRC+1) | Binary index of the source to pass |
| mux_out | output | DATA_W | Selected word, one cycle after sampling |

## Verification
The bench gives every source a distinct word, so a decoder that opens two registers, or opens the wrong one, shows extra or wrong bits at the output. It drives the indices 0 and N-1, and also indices of N and above. A decoder that wraps or truncates an out-of-range index would pass a real source instead of zero. It changes the unselected sources while the select is held, which exposes any leakage of those sources into the output. It also changes the inputs between edges and checks that the output stays put, which exposes a combinational path that bypasses the registers. Reset is asserted while a source is selected, so a register that ignores the clear would leave a stale word at the output.

// File: rtl/rgom_pkg.sv
package rgom_pkg;

  // Bits needed to encode 0..n, so that index n (one past the last source) exists
  function automatic int idx_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rgom_release_dec.sv
module rgom_release_dec #(
  parameter int NUM_SRC = 16,
  parameter int SEL_W   = 5
) (
  input  logic [SEL_W-1:0]   idx,
  output logic [NUM_SRC-1:0] open_vec
);

  // Compare against each legal index; anything else leaves every bit low
  always_comb begin
    open_vec = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (idx == SEL_W'(k)) open_vec[k] = 1'b1;
    end
  end

endmodule

// File: rtl/rgom_src_reg.sv
module rgom_src_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  // Synchronous clear acts as the AND gate of the multiplexer
  always_ff @(posedge clk) begin
    if (rst || !open_en) q <= '0;
    else                 q <= d;
  end

  // R4: a register that was not opened contributes nothing
  a_r4_closed_reg_zero: assert property (@(posedge clk) disable iff (rst)
    !open_en |=> (q == '0));

endmodule

// File: rtl/rgom_or_tree.sv
module rgom_or_tree #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_SRC*DATA_W-1:0] leaves,
  output logic [DATA_W-1:0]         root
);

  localparam int LVLS = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int PADW = 1 << LVLS;

  // Heap layout: node 1 is the root, nodes PADW..2*PADW-1 are leaves
  logic [DATA_W-1:0] node [1:2*PADW-1];

  for (genvar i = 0; i < PADW; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      assign node[PADW+i] = leaves[i*DATA_W +: DATA_W];
    end else begin : g_pad
      assign node[PADW+i] = '0;
    end
  end

  for (genvar j = 1; j < PADW; j++) begin : g_inner
    assign node[j] = node[2*j] | node[2*j+1];
  end

  assign root = node[1];

endmodule

// File: rtl/rgom_mux.sv
module rgom_mux #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [NUM_SRC*DATA_W-1:0]                src_data,
  input  logic [rgom_pkg::idx_bits(NUM_SRC)-1:0]   sel_idx,
  output logic [DATA_W-1:0]                        mux_out
);

  localparam int SEL_W = rgom_pkg::idx_bits(NUM_SRC);

  logic [NUM_SRC-1:0]        open_vec;
  logic [NUM_SRC*DATA_W-1:0] held;

  rgom_release_dec #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_dec (
    .idx      (sel_idx),
    .open_vec (open_vec)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    rgom_src_reg #(.DATA_W(DATA_W)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .open_en (open_vec[k]),
      .d       (src_data[k*DATA_W +: DATA_W]),
      .q       (held[k*DATA_W +: DATA_W])
    );
  end

  rgom_or_tree #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_tree (
    .leaves (held),
    .root   (mux_out)
  );

  // Independent reference selection, used only by the checks below
  logic              chk_in_range;
  logic [DATA_W-1:0] chk_word;
  always_comb begin
    chk_in_range = (sel_idx < SEL_W'(NUM_SRC));
    chk_word     = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (chk_in_range && (sel_idx == SEL_W'(k))) chk_word = src_data[k*DATA_W +: DATA_W];
    end
  end

  // R3: at most one source register is opened in any cycle
  a_r3_single_open: assert property (@(posedge clk) disable iff (rst)
    $onehot0(open_vec));

  // R2: in-range index passes the word sampled at the previous edge
  a_r2_selected_word: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(chk_in_range)) |-> (mux_out == $past(chk_word)));

  // R5: out-of-range index yields zero
  a_r5_range_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(chk_in_range) |-> (mux_out == '0));

  // R1: first cycle after reset reads zero
  a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mux_out == '0));

endmodule

// File: tb/rgom_mux_bench.sv
module rgom_mux_bench;

  localparam int N  = 16;
  localparam int W  = 32;
  localparam int SW = 5;
  localparam int NV = 10;

  localparam logic [SW-1:0] T_SEL [NV] = '{5'd0, 5'd15, 5'd7, 5'd3, 5'd16,
                                           5'd31, 5'd8, 5'd1, 5'd14, 5'd20};
  localparam logic [W-1:0] T_SEED [NV] = '{32'h0000_0001, 32'hA5A5_0F0F, 32'h1234_5678,
                                           32'hFFFF_0000, 32'hDEAD_BEEF, 32'h0BAD_F00D,
                                           32'h8000_0001, 32'h5555_AAAA, 32'hC0DE_1234,
                                           32'h7777_7777};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N*W-1:0]  src_data = '0;
  logic [SW-1:0]   sel_idx = '0;
  logic [W-1:0]    mux_out;
  int              total = 0;
  int              bad = 0;

  always #2 clk = ~clk;

  rgom_mux #(.NUM_SRC(N), .DATA_W(W)) u_rgom_mux (
    .clk      (clk),
    .rst      (rst),
    .src_data (src_data),
    .sel_idx  (sel_idx),
    .mux_out  (mux_out)
  );

  function automatic logic [W-1:0] word_of(input int k, input logic [W-1:0] seed);
    return seed ^ (32'(k) * 32'h9E37_79B1) ^ (32'h1 << k);
  endfunction

  function automatic logic [N*W-1:0] fill(input logic [W-1:0] seed);
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = word_of(k, seed);
    return v;
  endfunction

  function automatic logic [W-1:0] expect_of(input logic [SW-1:0] s, input logic [W-1:0] seed);
    return (int'(s) < N) ? word_of(int'(s), seed) : '0;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: output zero while in reset
    src_data = fill(32'hFACE_0001);
    sel_idx  = 5'd4;
    repeat (3) @(negedge clk);
    chk("R1 reset state", mux_out, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 R2 first load after reset", mux_out, word_of(4, 32'hFACE_0001));

    // Table walk: R2, R3, R5, R7
    for (int i = 0; i < NV; i++) begin
      src_data = fill(T_SEED[i]);
      sel_idx  = T_SEL[i];
      @(negedge clk);
      chk((int'(T_SEL[i]) < N) ? "R2 R3 table select" : "R5 table out of range",
          mux_out, expect_of(T_SEL[i], T_SEED[i]));
    end

    // R7: both ends selectable
    src_data = fill(32'h0F0F_3C3C);
    sel_idx  = 5'd0;
    @(negedge clk);
    chk("R7 index zero", mux_out, word_of(0, 32'h0F0F_3C3C));
    sel_idx  = 5'd15;
    @(negedge clk);
    chk("R7 last index", mux_out, word_of(15, 32'h0F0F_3C3C));

    // R4: disturb unselected sources, hold select and selected word
    sel_idx = 5'd3;
    @(negedge clk);
    for (int k = 0; k < N; k++) if (k != 3) src_data[k*W +: W] = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R4 unselected ignored", mux_out, word_of(3, 32'h0F0F_3C3C));

    // R6: mid-cycle change has no effect before the next edge
    src_data = fill(32'h1111_2222);
    sel_idx  = 5'd9;
    #1;
    chk("R6 stable between edges", mux_out, word_of(3, 32'h0F0F_3C3C));
    @(negedge clk);
    chk("R6 takes effect at edge", mux_out, word_of(9, 32'h1111_2222));

    // R5: index exactly N
    sel_idx = 5'd16;
    @(negedge clk);
    chk("R5 index equal count", mux_out, '0);

    // R1: reset with a valid select clears the output
    sel_idx = 5'd12;
    @(negedge clk);
    chk("R2 before reset", mux_out, word_of(12, 32'h1111_2222));
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears output", mux_out, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 R2 reload after reset", mux_out, word_of(12, 32'h1111_2222));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule